// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block is a one-bit processing unit for control code that works on individual flags and pin images instead of whole bytes. Its only accumulator is a carry flag. Beside it sits a private store of 256 single bits. The lower half of the address space stands for bits of internal RAM. The upper half stands for addressable special-function-register bits. The two halves are held in separate banks.

Each clock cycle a sequencer may present one operation as a 4-bit opcode, an 8-bit bit address and a valid strobe. The unit can do the following:

- move a bit into carry, or move carry into a bit;
- set, clear or complement one bit, or the carry;
- AND or OR a bit, or its complement, into carry;
- test a bit for a branch.

The sequencer uses the registered branch-taken result to redirect its own program counter. The store and the carry are visible from outside only through the carry output, so a bit is read by moving it into carry.

Results are registered. An operation accepted at one rising edge shows its carry, branch-taken and done values from that edge until the next one. Any bit or carry write made by an operation is seen by the operation in the very next cycle.

Top module: `bitproc_top`

## Requirements
- R1: After synchronous reset `rst`, `carry`, `branch_taken` and `done` are 0, and every one of the 256 bits reads 0.
- R2: Opcode 1 copies the addressed bit into carry. Opcode 2 copies carry into the addressed bit.
- R3: Opcodes 3, 4 and 5 set, clear and complement the addressed bit. They change no other bit and leave carry unchanged.
- R4: Opcodes 6, 7 and 8 set, clear and complement the carry itself. The bit address is ignored and no stored bit changes.
- R5: Opcode 9 replaces carry with carry AND bit. Opcode 11 replaces carry with carry OR bit.
- R6: Opcode 10 replaces carry with carry AND NOT bit. Opcode 12 replaces carry with carry OR NOT bit. In both forms the stored bit is left unchanged.
- R7: Opcode 13 gives `branch_taken`=1 when the bit is 1. Opcode 14 gives `branch_taken`=1 when the bit is 0. Neither changes carry or the bit. Every non-branch opcode gives `branch_taken`=0.
- R8: Opcode 15 gives `branch_taken`=1 and clears the bit when the bit is 1. When the bit is 0 it gives `branch_taken`=0 and changes nothing.
- R9: Addresses 0–127 and 128–255 select distinct bits. A write to address a never changes address a XOR 128.
- R10: A write made by an operation is seen by the operation accepted in the next cycle, including over long random runs.
- R11: While `op_valid` is 0, no bit and no carry changes, `done` is 0 and `branch_taken` is 0. Opcode 0 is a no-op that still raises `done`.
- R12: An operation accepted at a rising edge drives `done`=1, its `carry` and its `branch_taken` from that edge until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| bit_addr | input | 8 | Bit address: 0–127 RAM bits, 128–255 register bits |
| carry | output | 1 | Carry flag, which is the bit accumulator |
| branch_taken | output | 1 | Branch condition of the last accepted operation |
| done | output | 1 | An operation was accepted at the last edge |

## Verification
The carry-range assertions take for granted that `op_valid` is low during reset. Without that, the value carried across the reset boundary would be meaningless. The stimulus keeps `op_valid` at 0 until reset has been released for a cycle.

The assertions also assume that opcode and address are only meaningful when `op_valid` is high. The bench therefore drives junk opcodes during idle cycles to show they have no effect. All inputs change on the falling edge, so every input is settled at each capturing edge. The random phase confines addresses to a few bits in each bank, so writes and reads of the same bit collide often.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_MOVC = 4'd1,
    OP_MOVB = 4'd2,
    OP_SETB = 4'd3,
    OP_CLRB = 4'd4,
    OP_CPLB = 4'd5,
    OP_SETC = 4'd6,
    OP_CLRC = 4'd7,
    OP_CPLC = 4'd8,
    OP_ANL  = 4'd9,
    OP_ANLN = 4'd10,
    OP_ORL  = 4'd11,
    OP_ORLN = 4'd12,
    OP_JB   = 4'd13,
    OP_JNB  = 4'd14,
    OP_JBC  = 4'd15
  } op_e;

  typedef struct packed {
    logic wr_carry;   // operation may change carry
    logic wr_bit;     // operation always writes the addressed bit
    logic wr_cond;    // operation writes the bit only when branching
    logic branch;     // operation produces a branch condition
    logic invert;     // operand is the complement of the stored bit
  } ctrl_t;

endpackage

// File: rtl/bitproc_decode.sv
module bitproc_decode
  import bitproc_pkg::*;
(
  input  op_e   op,
  output ctrl_t ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (op)
      OP_MOVC, OP_SETC, OP_CLRC, OP_CPLC,
      OP_ANL, OP_ORL:   ctrl.wr_carry = 1'b1;
      OP_ANLN, OP_ORLN: begin
        ctrl.wr_carry = 1'b1;
        ctrl.invert   = 1'b1;
      end
      OP_MOVB, OP_SETB, OP_CLRB, OP_CPLB: ctrl.wr_bit = 1'b1;
      OP_JB:  ctrl.branch = 1'b1;
      OP_JNB: begin
        ctrl.branch = 1'b1;
        ctrl.invert = 1'b1;
      end
      OP_JBC: begin
        ctrl.branch  = 1'b1;
        ctrl.wr_cond = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
  import bitproc_pkg::*;
(
  input  logic  valid,
  input  op_e   op,
  input  ctrl_t ctrl,
  input  logic  cur_bit,
  input  logic  carry,
  output logic  nxt_carry,
  output logic  bit_we,
  output logic  bit_wval,
  output logic  take
);

  logic operand;

  assign operand = cur_bit ^ ctrl.invert;

  always_comb begin
    nxt_carry = carry;
    if (ctrl.wr_carry) begin
      unique case (op)
        OP_MOVC:          nxt_carry = cur_bit;
        OP_SETC:          nxt_carry = 1'b1;
        OP_CLRC:          nxt_carry = 1'b0;
        OP_CPLC:          nxt_carry = ~carry;
        OP_ANL, OP_ANLN:  nxt_carry = carry & operand;
        OP_ORL, OP_ORLN:  nxt_carry = carry | operand;
        default:          nxt_carry = carry;
      endcase
    end
  end

  always_comb begin
    unique case (op)
      OP_MOVB: bit_wval = carry;
      OP_SETB: bit_wval = 1'b1;
      OP_CPLB: bit_wval = ~cur_bit;
      default: bit_wval = 1'b0;   // clear and test-then-clear
    endcase
  end

  assign take   = valid & ctrl.branch & operand;
  assign bit_we = valid & (ctrl.wr_bit | (ctrl.wr_cond & take));

endmodule

// File: rtl/bitproc_bank.sv
module bitproc_bank #(
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          wval,
  output logic          rd
);

  logic [DEPTH-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst) mem <= '0;
    else if (we) mem[addr] <= wval;
  end

  assign rd = mem[addr];

  // R11: storage is untouched in any cycle without a write strobe
  assert_bank_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(we) |-> $stable(mem));

endmodule

// File: rtl/bitproc_store.sv
module bitproc_store #(
  parameter int ADDR_W      = 8,
  parameter int BANK_ADDR_W = 7,
  localparam int SEL_W      = ADDR_W - BANK_ADDR_W,
  localparam int NBANK      = 1 << SEL_W,
  localparam int DEPTH      = 1 << BANK_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wval,
  output logic              rd
);

  logic [SEL_W-1:0]       sel;
  logic [BANK_ADDR_W-1:0] lo;
  logic [NBANK-1:0]       bank_we;
  logic [NBANK-1:0]       bank_rd;

  assign sel = addr[ADDR_W-1:BANK_ADDR_W];
  assign lo  = addr[BANK_ADDR_W-1:0];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bank_we[g] = we & (sel == SEL_W'(g));
    bitproc_bank #(.DEPTH(DEPTH)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .we   (bank_we[g]),
      .addr (lo),
      .wval (wval),
      .rd   (bank_rd[g])
    );
  end

  assign rd = bank_rd[sel];

  // R9: a write lands in at most one bank
  assert_bank_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we));

endmodule

// File: rtl/bitproc_top.sv
module bitproc_top
  import bitproc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BANK_ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [ADDR_W-1:0] bit_addr,
  output logic              carry,
  output logic              branch_taken,
  output logic              done
);

  op_e   op;
  ctrl_t ctrl;
  logic  cur_bit, nxt_carry, bit_we, bit_wval, take;

  assign op = op_e'(op_code);

  bitproc_decode u_dec (.op(op), .ctrl(ctrl));

  bitproc_store #(.ADDR_W(ADDR_W), .BANK_ADDR_W(BANK_ADDR_W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .we   (bit_we),
    .addr (bit_addr),
    .wval (bit_wval),
    .rd   (cur_bit)
  );

  bitproc_alu u_alu (
    .valid     (op_valid),
    .op        (op),
    .ctrl      (ctrl),
    .cur_bit   (cur_bit),
    .carry     (carry),
    .nxt_carry (nxt_carry),
    .bit_we    (bit_we),
    .bit_wval  (bit_wval),
    .take      (take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry        <= 1'b0;
      branch_taken <= 1'b0;
      done         <= 1'b0;
    end else begin
      done         <= op_valid;
      branch_taken <= take;
      if (op_valid) carry <= nxt_carry;
    end
  end

  // R7: a taken branch only follows an accepted test operation
  assert_taken_branch_only_R7: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> $past(op_valid) &&
                     ($past(op) == OP_JB || $past(op) == OP_JNB || $past(op) == OP_JBC));

  // R5: AND forms can never raise carry
  assert_and_no_raise_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(op_valid) && ($past(op) == OP_ANL || $past(op) == OP_ANLN)
    |-> (!carry || $past(carry)));

  // R5: OR forms can never drop carry
  assert_or_no_drop_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(op_valid) && ($past(op) == OP_ORL || $past(op) == OP_ORLN)
    |-> (carry || !$past(carry)));

  // R3: bit-target, branch and no-op codes leave carry alone
  assert_carry_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(op_valid) &&
    ($past(op) == OP_MOVB || $past(op) == OP_SETB || $past(op) == OP_CLRB ||
     $past(op) == OP_CPLB || $past(op) == OP_JB   || $past(op) == OP_JNB  ||
     $past(op) == OP_JBC  || $past(op) == OP_NOP)
    |-> $stable(carry));

  // R11: idle cycles change neither carry nor the branch output
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(op_valid) |-> $stable(carry) && !branch_taken && !done);

endmodule

// File: tb/tb_bitproc_top.sv
module tb_bitproc_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [3:0] op_code;
  logic [7:0] bit_addr;
  logic       carry, branch_taken, done;

  bitproc_top dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .bit_addr(bit_addr), .carry(carry), .branch_taken(branch_taken), .done(done)
  );

  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    logic  c;
    logic  t;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  logic mbits [256];
  logic mcarry;
  bit   finished = 0;

  task automatic fail_line(string tag, string what, int act, int exp);
    n_fail++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  // monitor: compares each registered result against the queued expectation
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        n_vec++;
        fail_line("R12", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (carry !== e.c || branch_taken !== e.t) begin
          n_fail++;
          $display("FAIL %s carry/taken actual=%0d/%0d expected=%0d/%0d",
                   e.tag, carry, branch_taken, e.c, e.t);
        end
      end
    end
  end

  // driver: applies one operation and queues its expected result
  task automatic op(input logic [3:0] code, input logic [7:0] a, input string tag);
    logic b, t;
    exp_t e;
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = code;
    bit_addr = a;
    b = mbits[a];
    t = 1'b0;
    case (code)
      4'd1:  mcarry = b;
      4'd2:  mbits[a] = mcarry;
      4'd3:  mbits[a] = 1'b1;
      4'd4:  mbits[a] = 1'b0;
      4'd5:  mbits[a] = ~b;
      4'd6:  mcarry = 1'b1;
      4'd7:  mcarry = 1'b0;
      4'd8:  mcarry = ~mcarry;
      4'd9:  mcarry = mcarry & b;
      4'd10: mcarry = mcarry & ~b;
      4'd11: mcarry = mcarry | b;
      4'd12: mcarry = mcarry | ~b;
      4'd13: t = b;
      4'd14: t = ~b;
      4'd15: begin t = b; if (b) mbits[a] = 1'b0; end
      default: ;
    endcase
    e.c = mcarry; e.t = t; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input logic [3:0] junk);
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = junk;
    bit_addr = 8'd5;
    @(negedge clk);
    n_vec++;
    if (done !== 1'b0 || branch_taken !== 1'b0 || carry !== mcarry)
      fail_line("R11", "idle done/taken/carry", {done, branch_taken, carry},
                {2'b00, mcarry});
  endtask

  task automatic drain;
    @(negedge clk);
    op_valid = 1'b0;
    repeat (2) @(negedge clk);
    n_vec++;
    if (exp_q.size() != 0) fail_line("R12", "results outstanding", exp_q.size(), 0);
  endtask

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 256; i++) mbits[i] = 1'b0;
    mcarry   = 1'b0;
    rst      = 1'b1;
    op_valid = 1'b0;
    op_code  = 4'd6;
    bit_addr = 8'd0;
    repeat (4) @(negedge clk);
    n_vec++;
    if ({carry, branch_taken, done} !== 3'b000)
      fail_line("R1", "reset outputs", {carry, branch_taken, done}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1: every bit reads zero after reset
    for (int i = 0; i < 256; i++) op(4'd1, 8'(i), "R1");

    // R4: carry as target, address ignored
    op(4'd6, 8'd9, "R4"); op(4'd8, 8'd9, "R4"); op(4'd8, 8'd9, "R4");
    op(4'd7, 8'd9, "R4"); op(4'd1, 8'd9, "R4");

    // R2 and R10: move carry out, then read back immediately
    op(4'd6, 8'd0, "R2"); op(4'd2, 8'd5, "R2"); op(4'd7, 8'd0, "R2");
    op(4'd1, 8'd5, "R10"); op(4'd1, 8'd4, "R2");

    // R3: bit set/clear/complement, neighbours untouched
    op(4'd7, 8'd0, "R3");
    op(4'd3, 8'd7, "R3"); op(4'd1, 8'd6, "R3"); op(4'd1, 8'd7, "R3");
    op(4'd5, 8'd7, "R3"); op(4'd1, 8'd7, "R3"); op(4'd5, 8'd7, "R3");
    op(4'd4, 8'd7, "R3"); op(4'd1, 8'd7, "R3");

    // R9: bank separation at a and a^128
    op(4'd3, 8'd130, "R9"); op(4'd1, 8'd2, "R9"); op(4'd1, 8'd130, "R9");
    op(4'd3, 8'd127, "R9"); op(4'd1, 8'd255, "R9"); op(4'd1, 8'd127, "R9");

    // R5: AND/OR with plain operand
    op(4'd3, 8'd20, "R5"); op(4'd4, 8'd21, "R5");
    op(4'd6, 8'd0, "R5"); op(4'd9, 8'd20, "R5"); op(4'd9, 8'd21, "R5");
    op(4'd11, 8'd21, "R5"); op(4'd11, 8'd20, "R5");

    // R6: complemented operand, stored bit unchanged
    op(4'd6, 8'd0, "R6"); op(4'd10, 8'd21, "R6"); op(4'd10, 8'd20, "R6");
    op(4'd12, 8'd20, "R6"); op(4'd12, 8'd21, "R6");
    op(4'd1, 8'd20, "R6"); op(4'd1, 8'd21, "R6");

    // R7: plain and inverted test
    op(4'd13, 8'd20, "R7"); op(4'd13, 8'd21, "R7");
    op(4'd14, 8'd20, "R7"); op(4'd14, 8'd21, "R7"); op(4'd0, 8'd20, "R7");

    // R8: test-then-clear, taken and not taken
    op(4'd3, 8'd200, "R8"); op(4'd15, 8'd200, "R8"); op(4'd15, 8'd200, "R8");
    op(4'd1, 8'd200, "R8"); op(4'd15, 8'd201, "R8");

    // R11: idle cycles with junk opcodes
    op(4'd6, 8'd0, "R11");
    idle(4'd7); idle(4'd3); idle(4'd8);
    op(4'd1, 8'd5, "R11");

    // R10: random back-to-back run on a few colliding addresses
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op(lfsr[11:8], {lfsr[7], 5'd0, lfsr[1:0]}, "R10");
    end
    drain();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule